// File: doc/BRIEF.md
# Register-to-Register Instruction Executor

This block carries out the two-byte register-to-register instructions of a small 24-bit processor. A command is an opcode byte plus an operand byte. The operand byte holds two 4-bit register codes: the upper nibble is the first register (r1) and the lower nibble is the second (r2). The block reads both registers from its own register file, computes add, subtract, multiply, divide, move, clear or shift, and writes the result back. It then reports whether it recognised the opcode. A zero divisor is reported and the division is not performed.

The register file holds eight 24-bit registers, each reachable under a fixed 4-bit code:

| Code | Register |
|------|----------|
| 0 | accumulator |
| 1 | index |
| 2 | link |
| 3 | base |
| 4 | general S |
| 5 | general T |
| 8 | program counter |
| 9 | status word |

The other codes are unmapped. A host port can read any code and write any mapped code, so software can load operands and collect results.

Control is a two-state machine:
- ST_IDLE holds while no command arrives (transition "wait").
- ST_IDLE moves to ST_EXEC when `cmd_valid` is sampled high (transition "accept"). The command is latched on that edge.
- ST_EXEC always returns to ST_IDLE on the next edge (transition "retire"). The write-back happens on that edge.
- `done`, `handled` and `div_zero` are driven only in ST_EXEC.

Top module: `rr_exec`

## Requirements
- R1: After reset every mapped register reads zero. The codes map as 0 accumulator, 1 index, 2 link, 3 base, 4 S, 5 T, 8 program counter, 9 status word. A host read of any other code (6, 7, 10 to 15) returns all ones (0xFFFFFF).
- R2: A host write (`host_we` high at a clock edge) updates the mapped register named by `host_wr_code` from that edge on. A host write to an unmapped code changes nothing.
- R3: Opcode 0x90 sets r2 to r2 + r1, modulo 2^24. Opcode 0x94 sets r2 to r2 − r1, modulo 2^24. r1 is operand bits [7:4] and r2 is operand bits [3:0].
- R4: Opcode 0x98 sets r2 to the low 24 bits of the product r2 × r1.
- R5: Opcode 0x9C with a nonzero r1 sets r2 to the two's-complement quotient r2 / r1, rounded toward zero and truncated to 24 bits.
- R6: Opcode 0x9C with r1 equal to zero leaves every register unchanged. `div_zero` is high, together with `done` and `handled`, for that single cycle.
- R7: Opcode 0xAC copies r1 into r2. Opcode 0xB4 sets r1 to zero and ignores the lower nibble.
- R8: Opcode 0xA4 shifts r1 left, filling with zeros, by the count in operand bits [3:0] (0 to 15). Opcode 0xA8 shifts r1 right arithmetically, copying the sign bit in, by that count. Both write the result to r1.
- R9: When `cmd_valid` is sampled high while idle, `done` is high for exactly the next cycle, and the write-back is visible after the edge that ends that cycle. `cmd_valid` while `done` is high is ignored.
- R10: Any other opcode gives `done` with `handled` low and changes no register. `handled` is never high without `done`.
- R11: A result whose destination code is unmapped is dropped. An unmapped source code reads as all ones.
- R12: If an instruction write-back and a host write target the same register on the same edge, the instruction result is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_opcode | input | 8 | Instruction opcode byte |
| cmd_operand | input | 8 | Register byte: r1 in [7:4], r2 or shift count in [3:0] |
| done | output | 1 | High for the single execute cycle |
| handled | output | 1 | With done: opcode recognised |
| div_zero | output | 1 | With done: division by zero refused |
| host_we | input | 1 | Host register write enable |
| host_wr_code | input | 4 | Host write register code |
| host_wr_data | input | 24 | Host write data |
| host_rd_code | input | 4 | Host read register code |
| host_rd_data | output | 24 | Host read data (combinational) |

## Verification
The arithmetic opcodes are tried with the following operand patterns:
- small positive values, which separate the operand order of subtract and divide;
- mixed signs, which separate signed from unsigned division and arithmetic from logical right shift;
- large values that wrap at 24 bits, which expose missing truncation;
- a zero divisor, which must be refused;
- shift counts of 0, 4 and 15.

Operands that name the same register twice, unmapped codes as source and destination, and unknown opcodes separate the nibble decode and the code map from the datapath. A command held high through the execute cycle checks that the busy cycle ignores `cmd_valid`. A host write colliding with a write-back checks the priority between the two write sources.

// File: rtl/rr_exec_pkg.sv
package rr_exec_pkg;

    localparam int unsigned OPC_W     = 8;
    localparam int unsigned CODE_W    = 4;
    localparam int unsigned NUM_SLOTS = 8;
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);

    localparam logic [OPC_W-1:0] OPC_ADD = 8'h90;
    localparam logic [OPC_W-1:0] OPC_SUB = 8'h94;
    localparam logic [OPC_W-1:0] OPC_MUL = 8'h98;
    localparam logic [OPC_W-1:0] OPC_DIV = 8'h9C;
    localparam logic [OPC_W-1:0] OPC_SHL = 8'hA4;
    localparam logic [OPC_W-1:0] OPC_SHR = 8'hA8;
    localparam logic [OPC_W-1:0] OPC_MOV = 8'hAC;
    localparam logic [OPC_W-1:0] OPC_CLR = 8'hB4;

    typedef enum logic [3:0] {
        ALU_NONE, ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV,
        ALU_MOV,  ALU_CLR, ALU_SHL, ALU_SHR
    } alu_op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } state_e;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } slot_t;

    // Register code to physical slot; codes 6, 7 and 10..15 are unmapped.
    function automatic slot_t map_code(input logic [CODE_W-1:0] code);
        slot_t s;
        s.hit  = 1'b1;
        s.slot = '0;
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: s.slot = code[SLOT_W-1:0];
            4'd8:    s.slot = SLOT_W'(6);
            4'd9:    s.slot = SLOT_W'(7);
            default: s.hit  = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rr_decoder.sv
module rr_decoder
    import rr_exec_pkg::*;
(
    input  logic [OPC_W-1:0]    opcode,
    input  logic [2*CODE_W-1:0] operand,
    output alu_op_e             alu_op,
    output logic [CODE_W-1:0]   r1_code,
    output logic [CODE_W-1:0]   r2_code
);

    assign r1_code = operand[2*CODE_W-1:CODE_W];
    assign r2_code = operand[CODE_W-1:0];

    always_comb begin
        case (opcode)
            OPC_ADD: alu_op = ALU_ADD;
            OPC_SUB: alu_op = ALU_SUB;
            OPC_MUL: alu_op = ALU_MUL;
            OPC_DIV: alu_op = ALU_DIV;
            OPC_MOV: alu_op = ALU_MOV;
            OPC_CLR: alu_op = ALU_CLR;
            OPC_SHL: alu_op = ALU_SHL;
            OPC_SHR: alu_op = ALU_SHR;
            default: alu_op = ALU_NONE;
        endcase
    end

endmodule

// File: rtl/rr_alu.sv
module rr_alu
    import rr_exec_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] r1_val,
    input  logic [DATA_W-1:0] r2_val,
    input  logic [CODE_W-1:0] shamt,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              dest_r1,
    output logic              div_zero
);

    always_comb begin
        result   = '0;
        wr_en    = 1'b1;
        dest_r1  = 1'b0;
        div_zero = 1'b0;
        unique case (op)
            ALU_ADD: result = r2_val + r1_val;
            ALU_SUB: result = r2_val - r1_val;
            ALU_MUL: result = r2_val * r1_val;
            ALU_DIV: begin
                if (r1_val == '0) begin
                    div_zero = 1'b1;
                    wr_en    = 1'b0;
                end else begin
                    result = DATA_W'($signed(r2_val) / $signed(r1_val));
                end
            end
            ALU_MOV: result = r1_val;
            ALU_CLR: begin
                result  = '0;
                dest_r1 = 1'b1;
            end
            ALU_SHL: begin
                result  = r1_val << shamt;
                dest_r1 = 1'b1;
            end
            ALU_SHR: begin
                result  = DATA_W'($signed(r1_val) >>> shamt);
                dest_r1 = 1'b1;
            end
            ALU_NONE: wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/rr_regfile.sv
module rr_regfile
    import rr_exec_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ra_code,
    output logic [DATA_W-1:0] ra_data,
    input  logic [CODE_W-1:0] rb_code,
    output logic [DATA_W-1:0] rb_data,
    input  logic [CODE_W-1:0] rh_code,
    output logic [DATA_W-1:0] rh_data,
    input  logic              ex_we,
    input  logic [CODE_W-1:0] ex_code,
    input  logic [DATA_W-1:0] ex_data,
    input  logic              host_we,
    input  logic [CODE_W-1:0] host_code,
    input  logic [DATA_W-1:0] host_data
);

    localparam int unsigned NUM_RD = 3;

    logic [DATA_W-1:0] slot_q  [NUM_SLOTS];
    logic [CODE_W-1:0] rd_code [NUM_RD];
    logic [DATA_W-1:0] rd_val  [NUM_RD];
    slot_t             ex_map;
    slot_t             host_map;

    assign ex_map   = map_code(ex_code);
    assign host_map = map_code(host_code);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        logic              ex_hit;
        logic              host_hit;

        assign ex_hit   = ex_we && ex_map.hit && (ex_map.slot == SLOT_W'(g));
        assign host_hit = host_we && host_map.hit && (host_map.slot == SLOT_W'(g));

        // Instruction write-back outranks the host port.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (ex_hit) begin
                q <= ex_data;
            end else if (host_hit) begin
                q <= host_data;
            end
        end

        assign slot_q[g] = q;
    end

    assign rd_code[0] = ra_code;
    assign rd_code[1] = rb_code;
    assign rd_code[2] = rh_code;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        slot_t m;
        assign m         = map_code(rd_code[p]);
        assign rd_val[p] = m.hit ? slot_q[m.slot] : '1;
    end

    assign ra_data = rd_val[0];
    assign rb_data = rd_val[1];
    assign rh_data = rd_val[2];

endmodule

// File: rtl/rr_exec.sv
module rr_exec
    import rr_exec_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [OPC_W-1:0]    cmd_opcode,
    input  logic [2*CODE_W-1:0] cmd_operand,
    output logic                done,
    output logic                handled,
    output logic                div_zero,
    input  logic                host_we,
    input  logic [CODE_W-1:0]   host_wr_code,
    input  logic [DATA_W-1:0]   host_wr_data,
    input  logic [CODE_W-1:0]   host_rd_code,
    output logic [DATA_W-1:0]   host_rd_data
);

    state_e                state;
    state_e                state_nxt;
    logic [OPC_W-1:0]      opc_q;
    logic [2*CODE_W-1:0]   opd_q;

    alu_op_e               alu_op;
    logic [CODE_W-1:0]     r1_code;
    logic [CODE_W-1:0]     r2_code;
    logic [DATA_W-1:0]     r1_val;
    logic [DATA_W-1:0]     r2_val;
    logic [DATA_W-1:0]     alu_res;
    logic                  alu_we;
    logic                  alu_dest_r1;
    logic                  alu_dz;
    logic                  ex_we;
    logic [CODE_W-1:0]     ex_code;

    // State register and command latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            opc_q <= '0;
            opd_q <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && cmd_valid) begin
                opc_q <= cmd_opcode;
                opd_q <= cmd_operand;
            end
        end
    end

    // Transitions: wait, accept, retire.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = cmd_valid ? ST_EXEC : ST_IDLE;
            ST_EXEC: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs and write-back strobe.
    always_comb begin
        done     = 1'b0;
        handled  = 1'b0;
        div_zero = 1'b0;
        ex_we    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_EXEC: begin
                done     = 1'b1;
                handled  = (alu_op != ALU_NONE);
                div_zero = alu_dz;
                ex_we    = alu_we;
            end
        endcase
    end

    assign ex_code = alu_dest_r1 ? r1_code : r2_code;

    rr_decoder u_dec (
        .opcode  (opc_q),
        .operand (opd_q),
        .alu_op  (alu_op),
        .r1_code (r1_code),
        .r2_code (r2_code)
    );

    rr_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra_code   (r1_code),
        .ra_data   (r1_val),
        .rb_code   (r2_code),
        .rb_data   (r2_val),
        .rh_code   (host_rd_code),
        .rh_data   (host_rd_data),
        .ex_we     (ex_we),
        .ex_code   (ex_code),
        .ex_data   (alu_res),
        .host_we   (host_we),
        .host_code (host_wr_code),
        .host_data (host_wr_data)
    );

    rr_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (alu_op),
        .r1_val   (r1_val),
        .r2_val   (r2_val),
        .shamt    (r2_code),
        .result   (alu_res),
        .wr_en    (alu_we),
        .dest_r1  (alu_dest_r1),
        .div_zero (alu_dz)
    );

endmodule

// File: rtl/rr_exec_chk.sv
module rr_exec_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic done,
    input logic handled,
    input logic div_zero
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && cmd_valid) |=> done);

    // R9
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !cmd_valid) |=> !done);

    // R10
    handled_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handled |-> done);

    // R6
    div_zero_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (done && handled));

endmodule

bind rr_exec rr_exec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .done      (done),
    .handled   (handled),
    .div_zero  (div_zero)
);

// File: tb/rr_exec_bench.sv
module rr_exec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = '0;
    logic [7:0]  cmd_operand = '0;
    logic        done, handled, div_zero;
    logic        host_we = 1'b0;
    logic [3:0]  host_wr_code = '0;
    logic [23:0] host_wr_data = '0;
    logic [3:0]  host_rd_code = '0;
    logic [23:0] host_rd_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        bit    hnd;
        bit    dz;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    logic [23:0] mreg [16];

    always #5 clk = ~clk;

    rr_exec u_rr_exec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_operand(cmd_operand), .done(done), .handled(handled), .div_zero(div_zero),
        .host_we(host_we), .host_wr_code(host_wr_code), .host_wr_data(host_wr_data),
        .host_rd_code(host_rd_code), .host_rd_data(host_rd_data)
    );

    function automatic bit mapped(input logic [3:0] c);
        return (c <= 4'd5) || (c == 4'd8) || (c == 4'd9);
    endfunction

    function automatic logic [23:0] mread(input logic [3:0] c);
        return mapped(c) ? mreg[c] : 24'hFFFFFF;
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int c = 0; c < 16; c++) begin
            host_rd_code = 4'(c);
            #1;
            check($sformatf("%s reg code %0d", tag, c), host_rd_data, mread(4'(c)));
        end
    endtask

    task automatic host_write(input logic [3:0] c, input logic [23:0] d);
        @(negedge clk);
        host_we = 1'b1; host_wr_code = c; host_wr_data = d;
        @(negedge clk);
        host_we = 1'b0;
        if (mapped(c)) mreg[c] = d;
    endtask

    // Driver: model the instruction, queue the expected status, drive it.
    task automatic issue(input logic [7:0] op, input logic [7:0] opd, input string tag,
                         input bit poke_busy, input bit poke_host,
                         input logic [3:0] hs, input logic [23:0] hd);
        logic [3:0]  c1, c2, dst;
        logic [23:0] v1, v2, res;
        bit          hnd, dz, we;
        int          sa, sb;
        exp_t        e;
        c1 = opd[7:4]; c2 = opd[3:0];
        v1 = mread(c1); v2 = mread(c2);
        hnd = 1; dz = 0; we = 1; dst = c2; res = '0;
        case (op)
            8'h90: res = v2 + v1;
            8'h94: res = v2 - v1;
            8'h98: res = v2 * v1;
            8'h9C: begin
                if (v1 == 0) begin
                    dz = 1; we = 0;
                end else begin
                    sa = int'($signed(v2)); sb = int'($signed(v1));
                    res = 24'(sa / sb);
                end
            end
            8'hAC: res = v1;
            8'hB4: begin res = '0; dst = c1; end
            8'hA4: begin res = v1 << c2; dst = c1; end
            8'hA8: begin res = 24'(int'($signed(v1)) >>> c2); dst = c1; end
            default: begin hnd = 0; we = 0; end
        endcase
        e.hnd = hnd; e.dz = dz; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = op; cmd_operand = opd;
        @(negedge clk);
        if (poke_busy) begin
            cmd_opcode = 8'hB4; cmd_operand = 8'h00;
        end else begin
            cmd_valid = 1'b0;
        end
        if (poke_host) begin
            host_we = 1'b1; host_wr_code = hs; host_wr_data = hd;
        end
        @(negedge clk);
        cmd_valid = 1'b0; host_we = 1'b0;
        check({"R9 done one cycle, ", tag}, 24'(done), 24'd0);
        if (poke_host && mapped(hs)) mreg[hs] = hd;
        if (we && mapped(dst)) mreg[dst] = res;
        check_regs(tag);
    endtask

    task automatic run(input logic [7:0] op, input logic [7:0] opd, input string tag);
        issue(op, opd, tag, 0, 0, 4'd0, 24'd0);
    endtask

    // Monitor: pop expected status whenever done is seen.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected done", 24'd1, 24'd0);
                end else begin
                    e = exp_q.pop_front();
                    check({e.tag, " handled"}, 24'(handled), 24'(e.hnd));
                    check({e.tag, " div_zero (R6)"}, 24'(div_zero), 24'(e.dz));
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        repeat (3) @(negedge clk);
        check("R9 done in reset", 24'(done), 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R1 reset");

        host_write(4'd0, 24'd5);
        host_write(4'd1, 24'd7);
        host_write(4'd2, 24'h800000);
        host_write(4'd3, 24'h123456);
        host_write(4'd4, 24'hFFFFFD);
        host_write(4'd5, 24'd100);
        host_write(4'd8, 24'h7FFFFF);
        host_write(4'd9, 24'd2);
        host_write(4'd6, 24'hABCDEF);
        host_write(4'd12, 24'h00BEEF);
        check_regs("R2 host writes");

        run(8'h90, 8'h01, "R3 add X+=A");
        run(8'h90, 8'h83, "R3 add B+=PC");
        run(8'h90, 8'h22, "R3 add wrap L+=L");
        run(8'h94, 8'h05, "R3 sub T-=A");
        run(8'h94, 8'h45, "R3 sub T-=S neg");
        run(8'h98, 8'h45, "R4 mul T*=S");
        run(8'h98, 8'h88, "R4 mul wrap PC*=PC");
        run(8'h9C, 8'h45, "R5 div T/=S");
        run(8'h9C, 8'h05, "R5 div T/=A");
        run(8'h9C, 8'h40, "R5 div A/=S toward zero");
        run(8'hB4, 8'h9F, "R7 clear SW low nibble ignored");
        run(8'h9C, 8'h95, "R6 div by zero");
        run(8'hAC, 8'h38, "R7 move B to PC");
        run(8'hA4, 8'h34, "R8 shl B by 4");
        run(8'hA4, 8'h30, "R8 shl by 0");
        host_write(4'd1, 24'h800010);
        run(8'hA8, 8'h1F, "R8 shr X by 15 sign");
        run(8'hA8, 8'h52, "R8 shr T by 2");
        run(8'h00, 8'h01, "R10 unknown 0x00");
        run(8'hB0, 8'h45, "R10 unknown 0xB0");
        run(8'h90, 8'h06, "R11 add to unmapped dest");
        run(8'hAC, 8'h70, "R11 move unmapped src");
        issue(8'h90, 8'h35, "R9 busy cmd ignored", 1, 0, 4'd0, 24'd0);
        issue(8'h90, 8'h35, "R12 collision exec wins", 0, 1, 4'd5, 24'h0F0F0F);
        issue(8'h90, 8'h35, "R12 host other reg", 0, 1, 4'd3, 24'h000042);

        repeat (2) @(negedge clk);
        check("R9 queue drained", 24'(exp_q.size()), 24'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule